// File: doc/BRIEF.md
# Programmable Up/Down Counter-Timer Channel

This block is one 36-bit counter-timer channel with a single count input pin and a single output pin. Software chooses whether the channel counts up or down and whether it advances on every internal clock or on rising edges of the external pin. A two-bit mode field selects free counting, in which the count wraps at its ends, or divide-by-N counting, in which the count is reloaded from a programmed value at each terminal count. In divide-by-N mode the output is either a one-clock pulse per terminal count or a square wave that toggles at each terminal count, so that the output frequency is the step rate divided by 2N.

The load value input holds the contents of the host's load register. A load command presets the counter from it, an enable bit freezes the count without losing it, and a latch command copies the running count into a holding register that the host reads while counting goes on. A sticky terminal-count flag, cleared by a separate command, serves as an interrupt source for a controller outside this block.

Top module: `updown_timer`

## Requirements
- R1: After a synchronous active-low reset the count, the held count, the output and the terminal-count flag are all zero.
- R2: A load command presets the count to the load value at the next clock edge, takes priority over any step at that edge, and returns the square-wave output to 0.
- R3: With the internal source selected and enable high, the count changes by one at every clock edge: up by one when the direction input is 1, down by one when it is 0.
- R4: With the external source selected, the count advances once per rising edge of the count pin; a pin level first sampled high at clock edge k (low at edge k-1) changes the count at edge k+2, and a pin held high gives no further steps.
- R5: While enable is low the count holds its value (a load command still applies).
- R6: In free mode (mode 00) the count wraps modulo 2^36 (all ones to 0 counting up, 0 to all ones counting down); each wrap is a terminal count event, and the output stays at 0.
- R7: In divide mode (mode 01, 10 or 11) a step from the terminal value reloads the load value instead: the terminal value is all ones when counting up and 1 when counting down. Counting down from N divides by N; counting up, loading 2^36-N divides by N.
- R8: In pulse mode (mode 01 or 11) the output is high during the clock cycle that follows each edge at which a terminal count occurs, and low otherwise.
- R9: In square mode (mode 10) the output toggles at each terminal count event and holds its level between them.
- R10: A latch command captures, at the clock edge, the count as it was just before that edge; the held count does not change otherwise, and counting continues.
- R11: The terminal-count flag is set at each terminal count event and stays set until a clear command; a terminal event at the same edge as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pin | input | 1 | External count input, asynchronous |
| cfg_up | input | 1 | Count direction: 1 up, 0 down |
| cfg_src_ext | input | 1 | Step source: 1 external pin edges, 0 every clock |
| cfg_mode | input | 2 | 00 free, 01 divide with pulse, 10 divide with square wave, 11 divide with pulse |
| cfg_enable | input | 1 | Count enable; low freezes the count |
| load_value | input | 36 | Load register contents, used by load and reload |
| load_cmd | input | 1 | One-cycle preset of the count from load_value |
| latch_cmd | input | 1 | One-cycle capture of the running count |
| flag_clear | input | 1 | Clears the terminal-count flag |
| held_count | output | 36 | Count captured by the last latch command |
| timer_out | output | 1 | Channel output pin (pulse or square wave) |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The bench runs the counter with the internal step in both directions, with slow and fast toggling of the external pin to separate edge counting from level counting and to expose the two-stage synchronizer delay, and with enable dropped to tell a frozen count from a running one. Divide mode is driven with small load values in both directions so that many reloads occur, which distinguishes reloading at the terminal value from plain wrapping; free mode is loaded next to both ends of the range to show the wrap. Frequent latch commands with random clear and load commands compare the held count, output and flag against a bench model on every cycle, telling pulse from square output and a sticky from a transient flag.

// File: rtl/ctr_pkg.sv
// Shared definitions for the counter-timer channel.
// Assumes: mode field is two bits, values below are decoded by the output stage.
package ctr_pkg;
    typedef enum logic [1:0] {
        MODE_FREE       = 2'b00,
        MODE_DIV_PULSE  = 2'b01,
        MODE_DIV_SQUARE = 2'b10,
        MODE_DIV_PULSE2 = 2'b11
    } ctr_mode_e;
endpackage

// File: rtl/ctr_edge_sync.sv
// Synchronizes an asynchronous pin and flags its rising edges.
// Assumes: pin pulses are wider than one clock period at both levels.
module ctr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] shreg;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], pin};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

    // R4: one pin edge yields a single step request.
    assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ctr_core.sv
// Counter register with load, up/down step, wrap and divide-by-N reload.
// Assumes: step and load are single-cycle qualified requests; load wins.
module ctr_core #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         up,
    input  logic         divide,
    output logic [W-1:0] count,
    output logic         tc_evt
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ALL1 = '1;

    logic at_term;
    logic [W-1:0] step_val;

    // Decide whether the current count is the terminal value for this mode.
    always_comb begin
        if (up) at_term = (count == ALL1);
        else    at_term = (count == (divide ? ONE : ZERO));
        step_val = up ? count + ONE : count - ONE;
    end

    assign tc_evt = step & ~load & at_term;

    // Update the count: load first, then reload or step.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= load_val;
        else if (step) begin
            if (at_term && divide) count <= load_val;
            else                   count <= step_val;
        end
    end

    // R2: a load command presets the count.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R5: without step or load the count holds.
    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));
    // R7: a terminal step in divide mode reloads.
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && divide) |=> count == $past(load_val));
endmodule

// File: rtl/ctr_out.sv
// Output shaping (pulse or square wave) and sticky terminal-count flag.
// Assumes: tc_evt is a one-cycle event from the counter core.
module ctr_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tc_evt,
    input  logic       load,
    input  logic [1:0] mode,
    input  logic       clear,
    output logic       out,
    output logic       flag
);
    import ctr_pkg::*;

    ctr_mode_e mode_e;
    logic pulse_q;
    logic sq_q;
    logic is_pulse;
    logic is_square;

    assign mode_e    = ctr_mode_e'(mode);
    assign is_pulse  = (mode_e == MODE_DIV_PULSE) || (mode_e == MODE_DIV_PULSE2);
    assign is_square = (mode_e == MODE_DIV_SQUARE);

    // Register a one-cycle pulse per terminal event in pulse mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= tc_evt & is_pulse;
    end

    // Toggle the square wave at terminal events; a load returns it low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sq_q <= 1'b0;
        else if (load)               sq_q <= 1'b0;
        else if (tc_evt && is_square) sq_q <= ~sq_q;
    end

    // Set the flag on terminal events, clear on request; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (tc_evt) flag <= 1'b1;
        else if (clear)  flag <= 1'b0;
    end

    assign out = is_square ? sq_q : pulse_q;

    // R6: free mode produces no pulse.
    assert_free_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_FREE) |=> !pulse_q);
    // R9: the square wave only changes on terminal events or loads.
    assert_square_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_evt && !load) |=> $stable(sq_q));
    // R11: the flag holds until cleared.
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag);
endmodule

// File: rtl/updown_timer.sv
// Top of one counter-timer channel: step source select, counter core,
// output stage and the latch that reads the count while it runs.
// Assumes: command inputs are single-cycle pulses from the host register file.
module updown_timer #(
    parameter int W = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_pin,
    input  logic         cfg_up,
    input  logic         cfg_src_ext,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_enable,
    input  logic [W-1:0] load_value,
    input  logic         load_cmd,
    input  logic         latch_cmd,
    input  logic         flag_clear,
    output logic [W-1:0] held_count,
    output logic         timer_out,
    output logic         tc_flag
);
    logic         pin_rise;
    logic         step;
    logic         tc_evt;
    logic [W-1:0] count;

    ctr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cnt_pin),
        .rise  (pin_rise)
    );

    assign step = cfg_enable & (cfg_src_ext ? pin_rise : 1'b1);

    ctr_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load_cmd),
        .load_val (load_value),
        .up       (cfg_up),
        .divide   (cfg_mode != 2'b00),
        .count    (count),
        .tc_evt   (tc_evt)
    );

    ctr_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .tc_evt (tc_evt),
        .load   (load_cmd),
        .mode   (cfg_mode),
        .clear  (flag_clear),
        .out    (timer_out),
        .flag   (tc_flag)
    );

    // Capture the running count on a latch command.
    always_ff @(posedge clk) begin
        if (!rst_n)         held_count <= '0;
        else if (latch_cmd) held_count <= count;
    end

    // R10: the held count only changes on a latch command.
    assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_cmd |=> $stable(held_count));
    // R3: an internal-source step moves the count by exactly one.
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_cmd && !cfg_src_ext && !tc_evt && cfg_up) |=> count == $past(count) + W'(1));
endmodule

// File: tb/updown_timer_bench.sv
module updown_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 36;
    localparam int MAX_CYCLES = 100000;
    localparam logic [W-1:0] ALL1 = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_pin = 1'b0;
    logic cfg_up = 1'b1;
    logic cfg_src_ext = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic cfg_enable = 1'b0;
    logic [W-1:0] load_value = '0;
    logic load_cmd = 1'b0;
    logic latch_cmd = 1'b0;
    logic flag_clear = 1'b0;
    logic [W-1:0] held_count;
    logic timer_out;
    logic tc_flag;

    int checks = 0;
    int failures = 0;
    logic started = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_timer u_updown_timer (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .cfg_up(cfg_up),
        .cfg_src_ext(cfg_src_ext), .cfg_mode(cfg_mode), .cfg_enable(cfg_enable),
        .load_value(load_value), .load_cmd(load_cmd), .latch_cmd(latch_cmd),
        .flag_clear(flag_clear), .held_count(held_count), .timer_out(timer_out),
        .tc_flag(tc_flag)
    );

    // Bench model built from the requirements.
    logic [W-1:0] m_count = '0;
    logic [W-1:0] m_held = '0;
    logic [2:0]   m_sh = '0;
    logic         m_pulse = 1'b0;
    logic         m_sq = 1'b0;
    logic         m_flag = 1'b0;

    function automatic logic is_terminal(input logic [W-1:0] c, input logic up, input logic div);
        if (up) return c == ALL1;
        return c == (div ? W'(1) : W'(0));
    endfunction

    function automatic logic model_out(input logic [1:0] md, input logic sq, input logic pl);
        return (md == 2'b10) ? sq : pl;
    endfunction

    always @(posedge clk) begin
        logic stp, term, evt, dv;
        if (!rst_n) begin
            m_count <= '0; m_held <= '0; m_sh <= '0;
            m_pulse <= 1'b0; m_sq <= 1'b0; m_flag <= 1'b0;
        end else begin
            dv   = (cfg_mode != 2'b00);
            stp  = cfg_enable & (cfg_src_ext ? (m_sh[1] & ~m_sh[2]) : 1'b1);
            term = is_terminal(m_count, cfg_up, dv);
            evt  = stp & ~load_cmd & term;
            m_sh <= {m_sh[1:0], cnt_pin};
            if (load_cmd)             m_count <= load_value;
            else if (stp && term && dv) m_count <= load_value;
            else if (stp)             m_count <= cfg_up ? m_count + W'(1) : m_count - W'(1);
            if (latch_cmd) m_held <= m_count;
            m_pulse <= evt & cfg_mode[0];
            if (load_cmd) m_sq <= 1'b0;
            else if (evt && cfg_mode == 2'b10) m_sq <= ~m_sq;
            if (evt) m_flag <= 1'b1;
            else if (flag_clear) m_flag <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R10 held count", held_count, m_held);
            chk("R11 terminal flag", {35'd0, tc_flag}, {35'd0, m_flag});
            if (cfg_mode == 2'b10)
                chk("R9 square output", {35'd0, timer_out}, {35'd0, model_out(cfg_mode, m_sq, m_pulse)});
            else if (cfg_mode == 2'b00)
                chk("R6 free-mode output", {35'd0, timer_out}, {35'd0, model_out(cfg_mode, m_sq, m_pulse)});
            else
                chk("R8 pulse output", {35'd0, timer_out}, {35'd0, model_out(cfg_mode, m_sq, m_pulse)});
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Latch the count one edge, then release; leaves time at a negedge.
    task automatic do_latch();
        latch_cmd = 1'b1;
        cycles(1);
        latch_cmd = 1'b0;
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_value = v;
        load_cmd = 1'b1;
        cycles(1);
        load_cmd = 1'b0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1: reset state
        chk("R1 held count after reset", held_count, '0);
        chk("R1 output after reset", {35'd0, timer_out}, '0);
        chk("R1 flag after reset", {35'd0, tc_flag}, '0);
        started = 1'b1;

        // R2 then R3 up: load 10, five internal steps.
        do_load(36'd10);
        cfg_enable = 1'b1; cfg_up = 1'b1; cfg_src_ext = 1'b0; cfg_mode = 2'b00;
        cycles(5);
        cfg_enable = 1'b0;
        do_latch();
        chk("R3 up count 10+5", held_count, 36'd15);
        // R5: frozen while disabled.
        cycles(4);
        do_latch();
        chk("R5 frozen count", held_count, 36'd15);
        // R3 down: three steps.
        cfg_up = 1'b0; cfg_enable = 1'b1;
        cycles(3);
        cfg_enable = 1'b0;
        do_latch();
        chk("R3 down count 15-3", held_count, 36'd12);
        // R2: load while enabled wins over the step.
        cfg_enable = 1'b1;
        do_load(36'd100);
        cfg_enable = 1'b0;
        do_latch();
        chk("R2 load priority", held_count, 36'd100);

        // R4: external edges, pin held high gives a single step.
        do_load(36'd0);
        cfg_up = 1'b1; cfg_src_ext = 1'b1; cfg_enable = 1'b1;
        cycles(3);
        cnt_pin = 1'b1;
        cycles(1);
        do_latch();
        chk("R4 no step before sync delay", held_count, 36'd0);
        cycles(5);
        do_latch();
        chk("R4 one step per edge", held_count, 36'd1);
        cnt_pin = 1'b0;
        cycles(3);
        cnt_pin = 1'b1;
        cycles(4);
        cnt_pin = 1'b0;
        do_latch();
        chk("R4 second edge", held_count, 36'd2);

        // R6: free-mode wrap up and down sets flag.
        cfg_src_ext = 1'b0; cfg_enable = 1'b0; flag_clear = 1'b1;
        cycles(1);
        flag_clear = 1'b0;
        do_load(ALL1);
        cfg_enable = 1'b1;
        cycles(1);
        cfg_enable = 1'b0;
        chk("R6 flag after up wrap", {35'd0, tc_flag}, 36'd1);
        do_latch();
        chk("R6 up wrap to zero", held_count, 36'd0);
        cfg_up = 1'b0; cfg_enable = 1'b1;
        cycles(1);
        cfg_enable = 1'b0;
        do_latch();
        chk("R6 down wrap to all ones", held_count, ALL1);

        // R7/R8: divide-by-4 down, pulse mode.
        cfg_mode = 2'b01;
        do_load(36'd4);
        cfg_enable = 1'b1;
        cycles(4);
        chk("R8 pulse after reload", {35'd0, timer_out}, 36'd1);
        cfg_enable = 1'b0;
        do_latch();
        chk("R7 reload down to N", held_count, 36'd4);
        // R9: square, up divide by 3 with load 2^36-3.
        cfg_mode = 2'b10; cfg_up = 1'b1;
        do_load(ALL1 - 36'd2);
        cfg_enable = 1'b1;
        cycles(3);
        chk("R9 square high after first tc", {35'd0, timer_out}, 36'd1);
        cycles(3);
        chk("R9 square low after second tc", {35'd0, timer_out}, 36'd0);

        // Random phase against the model.
        for (int blk = 0; blk < 30; blk++) begin
            logic ext_slow;
            cfg_mode    = 2'($urandom_range(0, 3));
            cfg_up      = 1'($urandom_range(0, 1));
            cfg_src_ext = ($urandom_range(0, 3) == 0);
            ext_slow    = 1'($urandom_range(0, 1));
            if (cfg_up) load_value = ALL1 - 36'($urandom_range(0, 20));
            else        load_value = 36'($urandom_range(1, 20));
            load_cmd = 1'b1;
            cycles(1);
            for (int i = 0; i < 200; i++) begin
                load_cmd   = ($urandom_range(0, 63) == 0);
                latch_cmd  = ($urandom_range(0, 3) == 0);
                flag_clear = ($urandom_range(0, 7) == 0);
                cfg_enable = ($urandom_range(0, 7) != 0);
                if (ext_slow) begin
                    if ($urandom_range(0, 3) == 0) cnt_pin = ~cnt_pin;
                end else begin
                    cnt_pin = 1'($urandom_range(0, 1));
                end
                cycles(1);
            end
            load_cmd = 1'b0; latch_cmd = 1'b0; flag_clear = 1'b0;
        end

        done = 1'b1;
        summary();
    end
endmodule